// File: doc/BRIEF.md
# Scan Test Application Sequencer

This controller runs one scan chain of run-time length through a series of test patterns. It decides, cycle by cycle, whether the chain shifts or captures, and whether that cycle must run at functional clock rate. Stimulus bits come from a serial input stream and are forwarded to the chain input. Response bits leave the chain end and are checked against a serial stream of expected bits, which gives a sticky fail flag.

Three sequencing modes are supported. The first is a static stuck-at mode with a single slow capture. The second is a delay-test mode in which the transition is launched by a capture and caught by a second capture right after it. The third is a delay-test mode in which the transition is launched by the final shift. The response unload can overlap the next stimulus load, and only the final response is shifted out on its own. A non-overlapped order can also be selected for comparison.

A one-cycle start pulse latches the configuration and begins a run, even while a run is in progress. After the last unload the block reports completion and waits for the next start.

Top module: `scan_seq`

## Requirements
- R1: A start pulse latches mode, overlap, chain_len and pat_count, and clears fail. On the next cycle it begins the first shift of the first pattern. A start during a run abandons that run and restarts from the beginning.
- R2: With mode 0 (and code 3, which acts the same), every pattern is n shift cycles with scan_en=1, then one capture cycle with scan_en=0. at_speed stays 0 in this mode.
- R3: With overlap=1, the n load shifts of each pattern after the first also unload the previous response. Only the last response is unloaded alone. In modes 0 and 2 the active cycles total p*(n+1)+n; in mode 1 they total p*(n+2)+n.
- R4: With overlap=0, each pattern is loaded (no compare), captured, and then unloaded by n shift cycles. In modes 0 and 2 this takes p*(2n+1) active cycles; in mode 1 it takes p*(2n+2).
- R5: With mode 1, all n load shifts have at_speed=0. Two consecutive capture cycles with scan_en=0 follow, and both have at_speed=1.
- R6: With mode 2, the first n-1 load shifts have at_speed=0. The n-th load shift has at_speed=1 and scan_en=1. One capture cycle with at_speed=1 and scan_en=0 follows at once.
- R7: stim_pop is 1 exactly on load shift cycles. scan_in equals stim_bit on those cycles and is 0 on all others.
- R8: resp_valid is 1 exactly on cycles whose chain_so bit is a response bit; these are the unload shifts and the overlapped load shifts. If chain_so differs from exp_bit on such a cycle, fail is 1 from the next cycle on, until the next start.
- R9: busy is 1 on every cycle of a run. done rises the cycle after the final unload shift and holds until the next start. After reset, busy, done, fail, scan_en and chain_ce are all 0.
- R10: A start with chain_len=0 or pat_count=0 gives done on the next cycle, with no shift or capture cycle.
- R11: chain_ce is 1 on every shift and capture cycle of a run and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that latches configuration and starts a run |
| mode | input | 2 | 0 stuck-at, 1 capture-launched delay test, 2 shift-launched delay test, 3 as 0 |
| overlap | input | 1 | 1: unload overlaps the next load; 0: separate unload per pattern |
| chain_len | input | LEN_W | Chain length n |
| pat_count | input | PAT_W | Number of patterns p |
| stim_bit | input | 1 | Head of the serial stimulus stream |
| exp_bit | input | 1 | Head of the serial expected-response stream |
| chain_so | input | 1 | Last flop output of the scan chain |
| scan_en | output | 1 | 1 selects shift, 0 selects capture |
| chain_ce | output | 1 | Clock enable for the chain, for shift and capture cycles |
| at_speed | output | 1 | Cycle must run at the functional clock rate |
| scan_in | output | 1 | Serial input to the chain |
| stim_pop | output | 1 | Stimulus bit consumed this cycle |
| resp_valid | output | 1 | chain_so is compared this cycle; expected bit consumed |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The properties assume that start lasts a single cycle and that the chain length stays within the counter width. They also assume that mode and overlap matter only through the copy latched at start, so a change on those pins between starts must not move any check. The bench drives configuration only together with start, pulses start for exactly one cycle, and changes stim_bit, chain_so and exp_bit only away from the clock edge. It never lets a mismatch fall on a cycle other than a chosen response cycle, so a rise of fail can be traced to one compare.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    MODE_STUCK       = 2'd0,
    MODE_CAPLAUNCH   = 2'd1,
    MODE_SHIFTLAUNCH = 2'd2,
    MODE_STUCK_ALT   = 2'd3
  } test_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD   = 3'd1,
    PH_CAPT   = 3'd2,
    PH_CAPT2  = 3'd3,
    PH_UNLOAD = 3'd4,
    PH_DONE   = 3'd5
  } phase_e;

endpackage

// File: rtl/scan_seq_rst_sync.sv
module scan_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             overlap_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PAT_W-1:0] npat_i,
  output logic             scan_en_o,
  output logic             at_speed_o,
  output logic             chain_ce_o,
  output logic             load_o,
  output logic             cmp_o,
  output logic             busy_o,
  output logic             done_o
);

  phase_e             phase_q, phase_d;
  logic [LEN_W-1:0]   bit_q, bit_d;
  logic [PAT_W-1:0]   pat_q, pat_d;
  logic [PAT_W-1:0]   pat_inc;
  test_mode_e         mode_q;
  logic               ovl_q;
  logic [LEN_W-1:0]   len_q;
  logic [PAT_W-1:0]   npat_q;
  logic               last_bit;
  logic               is_cl, is_sl;
  logic               zero_cfg;

  assign is_cl    = (mode_q == MODE_CAPLAUNCH);
  assign is_sl    = (mode_q == MODE_SHIFTLAUNCH);
  assign last_bit = (bit_q == (len_q - 1'b1));
  assign pat_inc  = pat_q + 1'b1;
  assign zero_cfg = (len_i == '0) || (npat_i == '0);

  // next-state
  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    pat_d   = pat_q;
    if (start_i) begin
      phase_d = zero_cfg ? PH_DONE : PH_LOAD;
      bit_d   = '0;
      pat_d   = '0;
    end else begin
      case (phase_q)
        PH_LOAD: begin
          if (last_bit) begin
            bit_d   = '0;
            phase_d = PH_CAPT;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        PH_CAPT: begin
          if (is_cl) begin
            phase_d = PH_CAPT2;
          end else begin
            pat_d   = pat_inc;
            phase_d = (!ovl_q || (pat_inc == npat_q)) ? PH_UNLOAD : PH_LOAD;
          end
        end
        PH_CAPT2: begin
          pat_d   = pat_inc;
          phase_d = (!ovl_q || (pat_inc == npat_q)) ? PH_UNLOAD : PH_LOAD;
        end
        PH_UNLOAD: begin
          if (last_bit) begin
            bit_d   = '0;
            phase_d = (pat_q == npat_q) ? PH_DONE : PH_LOAD;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      pat_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      pat_q   <= pat_d;
    end
  end

  // configuration, enabled by start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STUCK;
      ovl_q  <= 1'b0;
      len_q  <= '0;
      npat_q <= '0;
    end else if (start_i) begin
      mode_q <= test_mode_e'(mode_i);
      ovl_q  <= overlap_i;
      len_q  <= len_i;
      npat_q <= npat_i;
    end
  end

  // output decode
  always_comb begin
    scan_en_o  = (phase_q == PH_LOAD) || (phase_q == PH_UNLOAD);
    load_o     = (phase_q == PH_LOAD);
    cmp_o      = (phase_q == PH_UNLOAD) ||
                 ((phase_q == PH_LOAD) && ovl_q && (pat_q != '0));
    busy_o     = (phase_q == PH_LOAD) || (phase_q == PH_CAPT) ||
                 (phase_q == PH_CAPT2) || (phase_q == PH_UNLOAD);
    chain_ce_o = busy_o;
    done_o     = (phase_q == PH_DONE);
    at_speed_o = ((phase_q == PH_CAPT) && (is_cl || is_sl)) ||
                 (phase_q == PH_CAPT2) ||
                 ((phase_q == PH_LOAD) && is_sl && last_bit);
  end

  // R2: stuck-at and shift-launched patterns capture for one cycle only
  assert_single_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && busy_o && $fell(scan_en_o) && !is_cl) |=> scan_en_o);

  // R5: capture-launched patterns capture on two consecutive at-speed cycles
  assert_double_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && busy_o && $fell(scan_en_o) && is_cl) |=> (!scan_en_o && at_speed_o));

  // R6: the at-speed last shift is followed at once by an at-speed capture
  assert_shift_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && is_sl && scan_en_o && at_speed_o) |=> (!scan_en_o && at_speed_o && busy_o));

  // R9: done holds until the next start
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R3: the bit counter stays inside the chain while shifting
  assert_bit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_o |-> (bit_q < len_q));

endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic cmp_en_i,
  input  logic so_i,
  input  logic exp_i,
  output logic fail_o
);

  logic fail_d;

  always_comb begin
    fail_d = fail_o;
    if (clear_i)                          fail_d = 1'b0;
    else if (cmp_en_i && (so_i != exp_i)) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_o <= 1'b0;
    else        fail_o <= fail_d;
  end

  // R8: a compared mismatch is flagged on the next cycle
  assert_mismatch_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && cmp_en_i && (so_i != exp_i)) |=> fail_o);

  // R8: the flag is sticky until cleared
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clear_i) |=> fail_o);

  // R1: start clears the flag
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !fail_o);

endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             overlap,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [PAT_W-1:0] pat_count,
  input  logic             stim_bit,
  input  logic             exp_bit,
  input  logic             chain_so,
  output logic             scan_en,
  output logic             chain_ce,
  output logic             at_speed,
  output logic             scan_in,
  output logic             stim_pop,
  output logic             resp_valid,
  output logic             busy,
  output logic             done,
  output logic             fail
);

  logic rst_sync_n;

  scan_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  scan_seq_ctrl #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start),
    .mode_i     (mode),
    .overlap_i  (overlap),
    .len_i      (chain_len),
    .npat_i     (pat_count),
    .scan_en_o  (scan_en),
    .at_speed_o (at_speed),
    .chain_ce_o (chain_ce),
    .load_o     (stim_pop),
    .cmp_o      (resp_valid),
    .busy_o     (busy),
    .done_o     (done)
  );

  scan_seq_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear_i  (start),
    .cmp_en_i (resp_valid),
    .so_i     (chain_so),
    .exp_i    (exp_bit),
    .fail_o   (fail)
  );

  assign scan_in = stim_pop & stim_bit;

  // R8: response bits are only taken while the chain shifts
  assert_resp_in_shift_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid |-> (scan_en && chain_ce));

  // R11: the chain is clocked whenever the sequencer asks for a shift
  assert_ce_on_shift_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scan_en |-> chain_ce);

endmodule

// File: tb/scan_seq_tb.sv
`timescale 1ns/1ps
module scan_seq_tb;

  localparam int LEN_W = 8;
  localparam int PAT_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, start, overlap, stim_bit, exp_bit, chain_so;
  logic [1:0]       mode;
  logic [LEN_W-1:0] chain_len;
  logic [PAT_W-1:0] pat_count;
  logic scan_en, chain_ce, at_speed, scan_in, stim_pop, resp_valid, busy, done, fail;

  scan_seq #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .overlap(overlap),
    .chain_len(chain_len), .pat_count(pat_count), .stim_bit(stim_bit),
    .exp_bit(exp_bit), .chain_so(chain_so), .scan_en(scan_en),
    .chain_ce(chain_ce), .at_speed(at_speed), .scan_in(scan_in),
    .stim_pop(stim_pop), .resp_valid(resp_valid), .busy(busy),
    .done(done), .fail(fail)
  );

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_q[$];   // {scan_en, at_speed, stim_pop, resp_valid}
  bit fail_pred;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int cycles_formula(input int m, input int ovl, input int n, input int p);
    int per;
    if (n == 0 || p == 0) return 0;
    per = n + ((m == 1) ? 2 : 1);
    return ovl ? (p * per + n) : (p * (per + n));
  endfunction

  task automatic build(input int m, input int ovl, input int n, input int p);
    exp_q.delete();
    if (n == 0 || p == 0) return;
    for (int k = 0; k < p; k++) begin
      for (int i = 0; i < n; i++)
        exp_q.push_back({1'b1, (m == 2 && i == n - 1), 1'b1, (ovl != 0 && k > 0)});
      exp_q.push_back({1'b0, (m == 1 || m == 2), 1'b0, 1'b0});
      if (m == 1) exp_q.push_back({1'b0, 1'b1, 1'b0, 1'b0});
      if (ovl == 0 || k == p - 1)
        for (int i = 0; i < n; i++) exp_q.push_back(4'b1001);
    end
  endtask

  task automatic run(input int m, input int ovl, input int n, input int p,
                     input int inj, input int abort_after);
    int cyc = 0;
    int rv_idx = 0;
    logic [3:0] e;
    string at_req;
    string tot_req;
    at_req  = (m == 1) ? "R5" : (m == 2) ? "R6" : "R2";
    tot_req = (n == 0 || p == 0) ? "R10" : (ovl != 0) ? "R3" : "R4";
    @(negedge clk);
    start = 1'b1; mode = 2'(m); overlap = 1'(ovl);
    chain_len = LEN_W'(n); pat_count = PAT_W'(p);
    @(negedge clk);
    start = 1'b0;
    fail_pred = 1'b0;
    build(m, ovl, n, p);
    while (exp_q.size() > 0) begin
      if (abort_after > 0 && cyc == abort_after) return;
      e = exp_q[0];
      stim_bit = 1'($urandom);
      chain_so = 1'($urandom);
      exp_bit  = chain_so ^ (e[0] && rv_idx == inj);
      #1;
      void'(exp_q.pop_front());
      if (cyc == 0) begin
        chk(fail == 1'b0, "R1", "fail after start", fail, 0);
        chk(scan_en == 1'b1 && stim_pop == 1'b1, "R1", "first shift", scan_en, 1);
      end
      chk(scan_en == e[3], (ovl != 0) ? "R3" : "R4", "scan_en", scan_en, e[3]);
      chk(at_speed == e[2], at_req, "at_speed", at_speed, e[2]);
      chk(stim_pop == e[1], "R7", "stim_pop", stim_pop, e[1]);
      chk(scan_in == (e[1] & stim_bit), "R7", "scan_in", scan_in, e[1] & stim_bit);
      chk(resp_valid == e[0], "R8", "resp_valid", resp_valid, e[0]);
      chk(chain_ce == 1'b1, "R11", "chain_ce", chain_ce, 1);
      chk(busy == 1'b1 && done == 1'b0, "R9", "busy/done in run", {busy, done}, 2);
      chk(fail == fail_pred, "R8", "fail", fail, fail_pred);
      if (e[0]) begin
        if (chain_so != exp_bit) fail_pred = 1'b1;
        rv_idx++;
      end
      cyc++;
      @(negedge clk);
    end
    stim_bit = 1'b0; chain_so = 1'b0; exp_bit = 1'b0;
    #1;
    chk(cyc == cycles_formula(m, ovl, n, p), tot_req, "active cycles", cyc,
        cycles_formula(m, ovl, n, p));
    chk(done == 1'b1 && busy == 1'b0, (cyc == 0) ? "R10" : "R9", "done after run",
        {done, busy}, 2);
    chk(scan_en == 1'b0 && chain_ce == 1'b0, "R11", "quiet after run",
        {scan_en, chain_ce}, 0);
    chk(fail == fail_pred, "R8", "fail after run", fail, fail_pred);
    repeat (3) @(negedge clk);
    #1;
    chk(done == 1'b1, "R9", "done holds", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; overlap = 1'b0;
    chain_len = '0; pat_count = '0; stim_bit = 1'b0; exp_bit = 1'b0; chain_so = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk({busy, done, fail, scan_en, chain_ce} == 5'b0, "R9", "reset state",
        {busy, done, fail, scan_en, chain_ce}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run(0, 1, 6, 3, -1, 0);   // R2 R3: 27 cycles
    run(0, 0, 6, 3, -1, 0);   // R4: 39 cycles
    run(1, 1, 5, 2, -1, 0);   // R5 overlapped
    run(1, 0, 3, 2, 2, 0);    // R5 R4 with a mismatch, R8
    run(2, 1, 4, 3, -1, 0);   // R6
    run(2, 0, 1, 2, -1, 0);   // R6 single-flop chain
    run(3, 1, 3, 2, 4, 0);    // code 3 as stuck-at, mismatch late, R8
    run(0, 1, 6, 3, 0, 10);   // abandoned run with fail set
    run(0, 1, 6, 2, -1, 0);   // R1 restart clears fail
    run(1, 1, 0, 3, -1, 0);   // R10 zero length
    run(2, 0, 4, 0, -1, 0);   // R10 zero patterns

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule